// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Block

This block is the software-visible control point of a dynamic memory controller. A CPU reaches three 32-bit registers over a plain register bus: a control word, a direct-command register and a timing register. The control word chooses who owns the SDRAM command and address pins, holds the scheduler and I/O logic in reset, and drives the clock-enable pin. The timing register supplies the scheduler with its wait counts and the CAS latency choice.

During power-up, software keeps the scheduler in reset and turns on direct mode. Each write to the command register then places a single active-low command on the SDRAM pins for one clock. The address and bank pins change in that same clock, so one write can carry a complete command such as a mode-register load. After initialisation, software turns direct mode off and releases the scheduler. From then on the pins follow the scheduler's own command and address outputs.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After reset, the control word reads 0x3 (direct mode on, scheduler reset asserted, clock enable low), the timing register reads 0x00217212 (tRP=2, tRCD=2, CL select 0, tREFI=740, tRFC=8), the command register reads 0, and all four command pins are high.
- R2: The control word is at offset 0x0. Bit 0 selects direct mode, bit 1 drives `core_rst`, and bit 2 drives `sdram_cke` from the clock edge that captures the write. Bits 31..3 are ignored on write and read as zero.
- R3: When direct mode is off, the command, address and bank pins equal the scheduler inputs in the same cycle.
- R4: The command register is at offset 0x4. Bit 0 is CS, bit 1 is WE, bit 2 is CAS and bit 3 is RAS. When direct mode is on, a write drives a 0 on every pin whose bit was 1 and a 1 on every other command pin. This lasts exactly the one cycle that follows the clock edge that captured the write.
- R5: When direct mode is on and no command cycle is in progress, all four command pins, including CS, are high. Back-to-back writes give one command cycle each.
- R6: The address is in bits 16..4 and the bank in bits 18..17 of the command register. Both reach the pins in the command cycle itself and hold there afterwards. Both read back. The command bits and bits 31..19 read as zero.
- R7: A command-register write while direct mode is off leaves the pins following the scheduler, but it still updates the stored address and bank.
- R8: The timing register is at offset 0x8. tRP is in bits 2..0, tRCD in bits 5..3, the CL3 select in bit 6, tREFI in bits 17..7 and tRFC in bits 21..18. Each field appears on its `tm_*` output after the write. Bits 31..22 are ignored and read as zero.
- R9: Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_re`. It is zero in a cycle that follows no read and for any offset other than 0x0, 0x4 and 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sched_cs_n | input | 1 | Scheduler chip select, active low |
| sched_we_n | input | 1 | Scheduler write enable, active low |
| sched_cas_n | input | 1 | Scheduler column strobe, active low |
| sched_ras_n | input | 1 | Scheduler row strobe, active low |
| sched_addr | input | 13 | Scheduler address |
| sched_ba | input | 2 | Scheduler bank |
| sdram_cs_n | output | 1 | SDRAM chip select pin |
| sdram_we_n | output | 1 | SDRAM write enable pin |
| sdram_cas_n | output | 1 | SDRAM column strobe pin |
| sdram_ras_n | output | 1 | SDRAM row strobe pin |
| sdram_addr | output | 13 | SDRAM address pins |
| sdram_ba | output | 2 | SDRAM bank pins |
| sdram_cke | output | 1 | SDRAM clock enable pin |
| core_rst | output | 1 | Reset to the scheduler and I/O logic |
| tm_rp | output | 3 | Precharge wait count |
| tm_rcd | output | 3 | Activate wait count |
| tm_cl3 | output | 1 | CAS latency 3 select |
| tm_refi | output | 11 | Refresh interval |
| tm_rfc | output | 4 | Refresh wait count |

## Verification
The bench sends all sixteen command-bit combinations through the command register, each with its own address and bank. It checks the pins in the command cycle and in the cycle after it. A design that stretched the pulse, left CS low between commands, or changed the address one cycle late would show a wrong pin value in one of those two cycles. Back-to-back writes are also tested, so a pulse built from an edge detector would merge them into one command. The bench sweeps every control-word value and many timing words with garbage in the reserved bits, checks the passthrough against a free-running stub scheduler, and checks that a command written with direct mode off leaks nothing onto the pins. Every offset in the address space is read, so an incomplete decode or an unregistered read path returns a nonzero or early value.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

  localparam int BUS_DW = 32;

  // register offsets (bytes)
  localparam int OFS_SYS = 'h0;
  localparam int OFS_CMD = 'h4;
  localparam int OFS_TIM = 'h8;

  // timing field widths
  localparam int TRP_W   = 3;
  localparam int TRCD_W  = 3;
  localparam int TREFI_W = 11;
  localparam int TRFC_W  = 4;

  // command lines, CS in the least significant position
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic cs;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef struct packed {
    logic [TRFC_W-1:0]  rfc;
    logic [TREFI_W-1:0] refi;
    logic               cl3;
    logic [TRCD_W-1:0]  rcd;
    logic [TRP_W-1:0]   rp;
  } timing_t;

  localparam int TIM_W = $bits(timing_t);

  localparam logic [2:0] SYS_RST = 3'b011;
  localparam timing_t TIM_RST = '{rfc: 4'd8, refi: 11'd740, cl3: 1'b0,
                                  rcd: 3'd2, rp: 3'd2};

  // active-high request to active-low pin levels
  function automatic cmd_t req_to_pins(cmd_t req);
    return ~req;
  endfunction

  function automatic logic [BUS_DW-1:0] timing_word(timing_t t);
    return BUS_DW'(t);
  endfunction

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import sdram_cfg_pkg::*;
#(
  parameter int BUS_AW = 4,
  parameter int ROW_W  = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bypass_en,
  output logic              core_rst,
  output logic              cke,
  output timing_t           tim,
  output logic [ROW_W-1:0]  byp_addr,
  output logic [BA_W-1:0]   byp_ba,
  output logic              byp_wr,
  output cmd_t              wr_cmd
);

  localparam int ADDR_LSB = CMD_W;
  localparam int BA_LSB   = ADDR_LSB + ROW_W;

  logic sel_sys, sel_cmd, sel_tim;
  assign sel_sys = (bus_addr == BUS_AW'(OFS_SYS));
  assign sel_cmd = (bus_addr == BUS_AW'(OFS_CMD));
  assign sel_tim = (bus_addr == BUS_AW'(OFS_TIM));

  logic [2:0]        sys_q;
  timing_t           tim_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BA_W-1:0]   ba_q;
  logic [BUS_DW-1:0] rd_val, rdata_q;

  wire unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= SYS_RST;
      tim_q  <= TIM_RST;
      addr_q <= '0;
      ba_q   <= '0;
    end else if (bus_we) begin
      if (sel_sys) sys_q <= bus_wdata[2:0];
      if (sel_tim) tim_q <= timing_t'(bus_wdata[TIM_W-1:0]);
      if (sel_cmd) begin
        addr_q <= bus_wdata[ADDR_LSB +: ROW_W];
        ba_q   <= bus_wdata[BA_LSB +: BA_W];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_sys) rd_val[2:0] = sys_q;
    if (sel_cmd) begin
      rd_val[ADDR_LSB +: ROW_W] = addr_q;
      rd_val[BA_LSB +: BA_W]    = ba_q;
    end
    if (sel_tim) rd_val = timing_word(tim_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_re ? rd_val : '0;
  end

  assign bus_rdata = rdata_q;
  assign bypass_en = sys_q[0];
  assign core_rst  = sys_q[1];
  assign cke       = sys_q[2];
  assign tim       = tim_q;
  assign byp_addr  = addr_q;
  assign byp_ba    = ba_q;
  assign byp_wr    = bus_we && sel_cmd;
  assign wr_cmd    = cmd_t'(bus_wdata[CMD_W-1:0]);

endmodule

// File: rtl/byp_cmd_gen.sv
module byp_cmd_gen
  import sdram_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic byp_wr,
  input  cmd_t wr_cmd,
  output cmd_t cmd_q
);

  // one-cycle request: cleared on any cycle without a command write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= byp_wr ? wr_cmd : '0;
  end

endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import sdram_cfg_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  logic             bypass_en,
  input  cmd_t             byp_req,
  input  logic [ROW_W-1:0] byp_addr,
  input  logic [BA_W-1:0]  byp_ba,
  input  cmd_t             sched_pins,
  input  logic [ROW_W-1:0] sched_addr,
  input  logic [BA_W-1:0]  sched_ba,
  output cmd_t             pins,
  output logic [ROW_W-1:0] pin_addr,
  output logic [BA_W-1:0]  pin_ba
);

  cmd_t byp_pins;
  assign byp_pins = req_to_pins(byp_req);

  assign pins     = bypass_en ? byp_pins : sched_pins;
  assign pin_addr = bypass_en ? byp_addr : sched_addr;
  assign pin_ba   = bypass_en ? byp_ba   : sched_ba;

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int BUS_AW = 4,
  parameter int ROW_W  = 13,
  parameter int BA_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic               sched_cs_n,
  input  logic               sched_we_n,
  input  logic               sched_cas_n,
  input  logic               sched_ras_n,
  input  logic [ROW_W-1:0]   sched_addr,
  input  logic [BA_W-1:0]    sched_ba,
  output logic               sdram_cs_n,
  output logic               sdram_we_n,
  output logic               sdram_cas_n,
  output logic               sdram_ras_n,
  output logic [ROW_W-1:0]   sdram_addr,
  output logic [BA_W-1:0]    sdram_ba,
  output logic               sdram_cke,
  output logic               core_rst,
  output logic [TRP_W-1:0]   tm_rp,
  output logic [TRCD_W-1:0]  tm_rcd,
  output logic               tm_cl3,
  output logic [TREFI_W-1:0] tm_refi,
  output logic [TRFC_W-1:0]  tm_rfc
);

  logic             bypass_en, byp_wr;
  cmd_t             wr_cmd, byp_req, sched_pins, pins;
  timing_t          tim;
  logic [ROW_W-1:0] byp_addr;
  logic [BA_W-1:0]  byp_ba;

  cfg_regfile #(.BUS_AW(BUS_AW), .ROW_W(ROW_W), .BA_W(BA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bypass_en (bypass_en),
    .core_rst  (core_rst),
    .cke       (sdram_cke),
    .tim       (tim),
    .byp_addr  (byp_addr),
    .byp_ba    (byp_ba),
    .byp_wr    (byp_wr),
    .wr_cmd    (wr_cmd)
  );

  byp_cmd_gen u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .byp_wr (byp_wr),
    .wr_cmd (wr_cmd),
    .cmd_q  (byp_req)
  );

  assign sched_pins = {sched_ras_n, sched_cas_n, sched_we_n, sched_cs_n};

  pin_mux #(.ROW_W(ROW_W), .BA_W(BA_W)) u_mux (
    .bypass_en  (bypass_en),
    .byp_req    (byp_req),
    .byp_addr   (byp_addr),
    .byp_ba     (byp_ba),
    .sched_pins (sched_pins),
    .sched_addr (sched_addr),
    .sched_ba   (sched_ba),
    .pins       (pins),
    .pin_addr   (sdram_addr),
    .pin_ba     (sdram_ba)
  );

  assign sdram_cs_n  = pins.cs;
  assign sdram_we_n  = pins.we;
  assign sdram_cas_n = pins.cas;
  assign sdram_ras_n = pins.ras;

  assign tm_rp   = tim.rp;
  assign tm_rcd  = tim.rcd;
  assign tm_cl3  = tim.cl3;
  assign tm_refi = tim.refi;
  assign tm_rfc  = tim.rfc;

endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk
  import sdram_cfg_pkg::*;
#(
  parameter int BUS_AW = 4,
  parameter int ROW_W  = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic              byp_wr,
  input logic              bypass_en,
  input logic              sched_cs_n,
  input logic              sched_we_n,
  input logic              sched_cas_n,
  input logic              sched_ras_n,
  input logic [ROW_W-1:0]  sched_addr,
  input logic [BA_W-1:0]   sched_ba,
  input logic              sdram_cs_n,
  input logic              sdram_we_n,
  input logic              sdram_cas_n,
  input logic              sdram_ras_n,
  input logic [ROW_W-1:0]  sdram_addr,
  input logic [BA_W-1:0]   sdram_ba,
  input logic              sdram_cke,
  input logic              core_rst
);

  logic [CMD_W-1:0] pin_vec;
  assign pin_vec = {sdram_ras_n, sdram_cas_n, sdram_we_n, sdram_cs_n};

  logic mapped;
  assign mapped = (bus_addr == BUS_AW'(OFS_SYS)) || (bus_addr == BUS_AW'(OFS_CMD))
               || (bus_addr == BUS_AW'(OFS_TIM));

  // R2
  ctl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BUS_AW'(OFS_SYS)) |=>
      (sdram_cke == $past(bus_wdata[2]) && core_rst == $past(bus_wdata[1])));

  // R2
  ctl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == BUS_AW'(OFS_SYS)) |=> (bus_rdata[BUS_DW-1:3] == '0));

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |-> (sdram_cs_n == sched_cs_n && sdram_we_n == sched_we_n &&
                    sdram_cas_n == sched_cas_n && sdram_ras_n == sched_ras_n &&
                    sdram_addr == sched_addr && sdram_ba == sched_ba));

  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_wr |=> (!bypass_en || pin_vec == ~$past(bus_wdata[CMD_W-1:0])));

  // R5
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_wr |=> (!bypass_en || pin_vec == '1));

  // R6
  addr_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_wr |=> (!bypass_en || (sdram_addr == $past(bus_wdata[CMD_W +: ROW_W]) &&
                               sdram_ba == $past(bus_wdata[CMD_W+ROW_W +: BA_W]))));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_wr && bypass_en) |=> (!bypass_en || ($stable(sdram_addr) && $stable(sdram_ba))));

  // R9
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mapped) |=> (bus_rdata == '0));

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));

endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(.BUS_AW(BUS_AW), .ROW_W(ROW_W), .BA_W(BA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .byp_wr      (byp_wr),
  .bypass_en   (bypass_en),
  .sched_cs_n  (sched_cs_n),
  .sched_we_n  (sched_we_n),
  .sched_cas_n (sched_cas_n),
  .sched_ras_n (sched_ras_n),
  .sched_addr  (sched_addr),
  .sched_ba    (sched_ba),
  .sdram_cs_n  (sdram_cs_n),
  .sdram_we_n  (sdram_we_n),
  .sdram_cas_n (sdram_cas_n),
  .sdram_ras_n (sdram_ras_n),
  .sdram_addr  (sdram_addr),
  .sdram_ba    (sdram_ba),
  .sdram_cke   (sdram_cke),
  .core_rst    (core_rst)
);

// File: tb/sdram_cfg_regs_test.sv
module sdram_cfg_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int BA_W  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sched_cs_n, sched_we_n, sched_cas_n, sched_ras_n;
  logic [ROW_W-1:0] sched_addr;
  logic [BA_W-1:0]  sched_ba;
  logic        sdram_cs_n, sdram_we_n, sdram_cas_n, sdram_ras_n;
  logic [ROW_W-1:0] sdram_addr;
  logic [BA_W-1:0]  sdram_ba;
  logic        sdram_cke, core_rst;
  logic [2:0]  tm_rp, tm_rcd;
  logic        tm_cl3;
  logic [10:0] tm_refi;
  logic [3:0]  tm_rfc;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // stub scheduler: free-running pattern on its command outputs
  logic [7:0] stub_cnt = '0;
  always_ff @(posedge clk) stub_cnt <= stub_cnt + 8'd1;
  assign {sched_ras_n, sched_cas_n, sched_we_n, sched_cs_n} = stub_cnt[3:0];
  assign sched_addr = ROW_W'(stub_cnt * 37 + 5);
  assign sched_ba   = stub_cnt[5:4];

  sdram_cfg_regs uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pins_now();
    return {28'd0, sdram_ras_n, sdram_cas_n, sdram_we_n, sdram_cs_n};
  endfunction

  function automatic logic [31:0] stub_pins();
    return {28'd0, sched_ras_n, sched_cas_n, sched_we_n, sched_cs_n};
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] rd, w, exp;
    logic [12:0] a;
    logic [1:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(pins_now() == 32'hF, "R1 idle pins", pins_now(), 32'hF);
    chk(sdram_cke == 1'b0, "R1 cke", 32'(sdram_cke), 32'd0);
    chk(core_rst == 1'b1, "R1 core_rst", 32'(core_rst), 32'd1);
    bus_rd(4'h0, rd); chk(rd == 32'h3, "R1 ctl reset", rd, 32'h3);
    bus_rd(4'h8, rd); chk(rd == 32'h0021_7212, "R1 timing reset", rd, 32'h0021_7212);
    bus_rd(4'h4, rd); chk(rd == 32'h0, "R1 cmd reset", rd, 32'h0);

    // R2 / R3 control word sweep with garbage in reserved bits
    for (int v = 0; v < 8; v++) begin
      bus_wr(4'h0, 32'hA5A5_A5A0 | 32'(v) | 32'(v << 5));
      chk(sdram_cke == v[2], "R2 cke", 32'(sdram_cke), 32'(v[2]));
      chk(core_rst == v[1], "R2 core_rst", 32'(core_rst), 32'(v[1]));
      if (v[0]) chk(pins_now() == 32'hF, "R5 idle in direct mode", pins_now(), 32'hF);
      else      chk(pins_now() == stub_pins(), "R3 passthrough", pins_now(), stub_pins());
      bus_rd(4'h0, rd);
      chk(rd == 32'(v), "R2 ctl readback", rd, 32'(v));
    end

    // R3 passthrough over many stub patterns
    bus_wr(4'h0, 32'h6);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      chk(pins_now() == stub_pins() && sdram_addr == sched_addr && sdram_ba == sched_ba,
          "R3 passthrough sweep", {pins_now()[3:0], 1'b0, sdram_ba, sdram_addr},
          {stub_pins()[3:0], 1'b0, sched_ba, sched_addr});
    end

    // R7 command write with direct mode off
    bus_wr(4'h4, 32'h0000_000F | (32'h1ABC << 4) | (32'h2 << 17));
    chk(pins_now() == stub_pins(), "R7 no leak", pins_now(), stub_pins());
    bus_rd(4'h4, rd);
    exp = (32'h1ABC << 4) | (32'h2 << 17);
    chk(rd == exp, "R7 fields stored", rd, exp);
    bus_wr(4'h0, 32'h7);
    chk(pins_now() == 32'hF && sdram_addr == 13'h1ABC && sdram_ba == 2'h2,
        "R7 held after direct on", {pins_now()[3:0], 13'd0, sdram_ba, sdram_addr},
        {4'hF, 13'd0, 2'h2, 13'h1ABC});

    // R4 / R5 / R6 all command combinations
    for (int c = 0; c < 16; c++) begin
      a = 13'((c * 517 + 3) % 8192);
      b = 2'(c % 4);
      w = 32'hFFF8_0000 | 32'(c) | (32'(a) << 4) | (32'(b) << 17);
      bus_wr(4'h4, w);
      exp = 32'(~c[3:0] & 4'hF);
      chk(pins_now() == exp, "R4 command pins", pins_now(), exp);
      chk(sdram_addr == a && sdram_ba == b, "R6 same-cycle address",
          {17'd0, sdram_ba, sdram_addr}, {17'd0, b, a});
      @(negedge clk);
      chk(pins_now() == 32'hF, "R5 return to idle", pins_now(), 32'hF);
      chk(sdram_addr == a && sdram_ba == b, "R6 address held",
          {17'd0, sdram_ba, sdram_addr}, {17'd0, b, a});
      bus_rd(4'h4, rd);
      exp = (32'(a) << 4) | (32'(b) << 17);
      chk(rd == exp, "R6 readback", rd, exp);
    end

    // R5 back-to-back commands
    @(negedge clk);
    bus_addr = 4'h4; bus_we = 1'b1; bus_wdata = 32'h0000_0009;
    @(negedge clk);
    chk(pins_now() == 32'h6, "R5 first of pair", pins_now(), 32'h6);
    bus_wdata = 32'h0000_0006;
    @(negedge clk);
    bus_we = 1'b0;
    chk(pins_now() == 32'h9, "R5 second of pair", pins_now(), 32'h9);
    @(negedge clk);
    chk(pins_now() == 32'hF, "R5 idle after pair", pins_now(), 32'hF);

    // R8 timing sweep
    for (int i = 0; i < 64; i++) begin
      logic [2:0]  rp, rcd;
      logic        cl;
      logic [10:0] refi;
      logic [3:0]  rfc;
      rp = 3'(i % 8); rcd = 3'(i / 8); cl = i[0] ^ i[3];
      refi = 11'((i * 29 + 7) % 2048); rfc = 4'((i * 5) % 16);
      exp = 32'(rp) | (32'(rcd) << 3) | (32'(cl) << 6) | (32'(refi) << 7) | (32'(rfc) << 18);
      bus_wr(4'h8, exp | (32'(i) << 22) | 32'hC000_0000);
      chk(tm_rp == rp && tm_rcd == rcd && tm_cl3 == cl && tm_refi == refi && tm_rfc == rfc,
          "R8 timing outputs", {tm_rfc, tm_refi, tm_cl3, tm_rcd, tm_rp}, exp);
      bus_rd(4'h8, rd);
      chk(rd == exp, "R8 timing readback", rd, exp);
    end

    // R9 read latency and unmapped offsets
    @(negedge clk);
    bus_addr = 4'h0; bus_re = 1'b1;
    chk(bus_rdata == 32'h0, "R9 not before edge", bus_rdata, 32'h0);
    @(negedge clk);
    bus_re = 1'b0;
    chk(bus_rdata == 32'h7, "R9 one cycle latency", bus_rdata, 32'h7);
    @(negedge clk);
    chk(bus_rdata == 32'h0, "R9 zero without read", bus_rdata, 32'h0);
    for (int o = 0; o < 16; o++) begin
      if (o != 0 && o != 4 && o != 8) begin
        bus_rd(4'(o), rd);
        chk(rd == 32'h0, "R9 unmapped offset", rd, 32'h0);
      end
    end

    report();
  end

endmodule